// File: doc/BRIEF.md
# Floating-Point Stage Reservation Scoreboard

This block decides, cycle by cycle, whether a floating-point or integer-multiply operation may enter a pipeline without colliding with operations that are already in flight. There are five shared resources: four floating-point pipeline stages, called stage0 to stage3, and one integer-multiplier resource. The multiplier can never be busy in the same cycle as stage1. Each operation class has a fixed plan that says which resources it uses in each future cycle.

A request is offered as a valid bit and a class code. The block compares the class plan against a window of reservations that have already been granted. If nothing collides, the block raises `accept` in the same cycle and records the plan. If something collides, it raises `stall` and records nothing. The requester holds or retries as it sees fit. The window advances by one cycle on every clock.

For every accepted operation, `resultReady` pulses exactly the class latency in cycles after the accept cycle. The block tracks no data and no operands.

Top module: `fpu_stage_scoreboard`

## Requirements
- R1: Class codes are: 0 single arithmetic/compare, 1 single divide, 2 double add/sub/mul, 3 double divide, 4 double conversion, 5 integer multiply, 6 status-register load. When `reqValid` is low, `accept` and `stall` are both low. A valid request with class 0 to 6 raises exactly one of `accept` and `stall` in the same cycle.
- R2: A request is stalled when any resource in its plan is already reserved in the same future cycle. A stalled request reserves nothing and produces no result pulse.
- R3: Class code 7 is ignored. It raises neither `accept` nor `stall`, reserves nothing and produces no result pulse.
- R4: Class 0 uses stage0+stage1 one cycle after issue, then stage2. Its result pulse comes 3 cycles after accept.
- R5: Class 1 uses stage0+stage1+stage3, then stage2+stage3, then stage3 for 7 cycles, then stage1+stage3, then stage2. Its result pulse comes 12 cycles after accept.
- R6: Class 2 uses stage0+stage1, then stage1+stage2 for 5 cycles, then stage2. Its result pulse comes 8 cycles after accept.
- R7: Class 3 uses stage0+stage1+stage3, stage1+stage2+stage3, stage2+stage3, stage3 for 16 cycles, stage1+stage3, stage1+stage2+stage3 for 2 cycles, then stage2. Its result pulse comes 25 cycles after accept.
- R8: Class 4 uses stage0+stage1, then stage1+stage2, then stage2. Its result pulse comes 4 cycles after accept.
- R9: Class 5 uses the multiplier for 4 cycles, then stage2, with a result pulse 4 cycles after accept. A request is also stalled when it would put stage1 and the multiplier into the same cycle.
- R10: Class 6 uses nothing in the first cycle after issue, then stage1 for 3 cycles. Its result pulse comes 4 cycles after accept.
- R11: Reset clears all reservations and pending result pulses. `resultReady` is low in the first cycle after reset.
- R12: Reservations move one cycle closer every clock. A request whose plan only touches cycles after an earlier reservation has ended is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | A request is offered this cycle |
| reqClass | input | 3 | Class code of the offered request |
| accept | output | 1 | The request is granted this cycle |
| stall | output | 1 | The request collides with a reservation and is refused |
| resultReady | output | 1 | One-cycle pulse when an accepted operation reaches its latency |

## Verification
A new request's grant or refusal can fall in the same cycle as the result pulse of an older operation, and both must be judged independently.

The vector sequence is arranged so that both combinations occur: in one cycle a request is stalled while a result pulse is due, and in another cycle a request is accepted while a pulse is due. Both are checked against hand-derived reservation timelines.

Separate probes place a second request at a chosen distance after a first one. This shows where each plan ends, where the multiplier/stage1 exclusion bites, and that refused or ignored requests leave no pulse behind.

// File: rtl/fpu_sb_pkg.sv
package fpu_sb_pkg;

  localparam int RES_W     = 5;
  localparam int PAT_DEPTH = 23;
  localparam int LAT_MAX   = 25;
  localparam int LAT_W     = $clog2(LAT_MAX + 1);
  localparam int CLS_W     = 3;

  localparam int RB_F0  = 0;
  localparam int RB_F1  = 1;
  localparam int RB_F2  = 2;
  localparam int RB_F3  = 3;
  localparam int RB_MUL = 4;

  typedef logic [RES_W-1:0] resMask_t;

  typedef enum logic [CLS_W-1:0] {
    CLS_SP_ARITH  = 3'd0,
    CLS_SP_DIV    = 3'd1,
    CLS_DP_ARITH  = 3'd2,
    CLS_DP_DIV    = 3'd3,
    CLS_DP_CONV   = 3'd4,
    CLS_INT_MUL   = 3'd5,
    CLS_STAT_LOAD = 3'd6,
    CLS_NONE      = 3'd7
  } opClass_e;

  typedef struct packed {
    logic             merge;
    logic             launch;
    logic [LAT_W-1:0] latency;
  } ctrlStrobe_t;

  localparam resMask_t M_F0  = resMask_t'(1) << RB_F0;
  localparam resMask_t M_F1  = resMask_t'(1) << RB_F1;
  localparam resMask_t M_F2  = resMask_t'(1) << RB_F2;
  localparam resMask_t M_F3  = resMask_t'(1) << RB_F3;
  localparam resMask_t M_MUL = resMask_t'(1) << RB_MUL;

  // Resource use of a class at a step; step 0 is the cycle after issue.
  function automatic resMask_t stepMask(opClass_e cls, int step);
    resMask_t m;
    m = '0;
    case (cls)
      CLS_SP_ARITH: begin
        if (step == 0)      m = M_F0 | M_F1;
        else if (step == 1) m = M_F2;
      end
      CLS_SP_DIV: begin
        if (step == 0)                   m = M_F0 | M_F1 | M_F3;
        else if (step == 1)              m = M_F2 | M_F3;
        else if (step >= 2 && step <= 8) m = M_F3;
        else if (step == 9)              m = M_F1 | M_F3;
        else if (step == 10)             m = M_F2;
      end
      CLS_DP_ARITH: begin
        if (step == 0)                   m = M_F0 | M_F1;
        else if (step >= 1 && step <= 5) m = M_F1 | M_F2;
        else if (step == 6)              m = M_F2;
      end
      CLS_DP_DIV: begin
        if (step == 0)                     m = M_F0 | M_F1 | M_F3;
        else if (step == 1)                m = M_F1 | M_F2 | M_F3;
        else if (step == 2)                m = M_F2 | M_F3;
        else if (step >= 3 && step <= 18)  m = M_F3;
        else if (step == 19)               m = M_F1 | M_F3;
        else if (step == 20 || step == 21) m = M_F1 | M_F2 | M_F3;
        else if (step == 22)               m = M_F2;
      end
      CLS_DP_CONV: begin
        if (step == 0)      m = M_F0 | M_F1;
        else if (step == 1) m = M_F1 | M_F2;
        else if (step == 2) m = M_F2;
      end
      CLS_INT_MUL: begin
        if (step >= 0 && step <= 3) m = M_MUL;
        else if (step == 4)         m = M_F2;
      end
      CLS_STAT_LOAD: begin
        if (step >= 1 && step <= 3) m = M_F1;
      end
      default: m = '0;
    endcase
    return m;
  endfunction

  function automatic logic [LAT_W-1:0] classLatency(opClass_e cls);
    case (cls)
      CLS_SP_ARITH:  return LAT_W'(3);
      CLS_SP_DIV:    return LAT_W'(12);
      CLS_DP_ARITH:  return LAT_W'(8);
      CLS_DP_DIV:    return LAT_W'(25);
      CLS_DP_CONV:   return LAT_W'(4);
      CLS_INT_MUL:   return LAT_W'(4);
      CLS_STAT_LOAD: return LAT_W'(4);
      default:       return '0;
    endcase
  endfunction

endpackage

// File: rtl/fpu_sb_ctrl.sv
module fpu_sb_ctrl
  import fpu_sb_pkg::*;
#(
  parameter int DEPTH = PAT_DEPTH
) (
  input  logic                  reqValid,
  input  logic [CLS_W-1:0]      reqClass,
  input  logic [DEPTH-1:0][RES_W-1:0] resvView,
  output logic [DEPTH-1:0][RES_W-1:0] pattern,
  output ctrlStrobe_t           strobe,
  output logic                  accept,
  output logic                  stall
);

  logic [DEPTH-1:0] slotHit;
  logic             conflict;
  logic             knownClass;
  opClass_e         cls;

  assign cls = opClass_e'(reqClass);

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    resMask_t patK;
    resMask_t resK;
    assign patK       = stepMask(cls, k);
    assign resK       = resvView[k];
    assign pattern[k] = patK;
    // Same-resource overlap, plus the multiplier / stage1 exclusion.
    assign slotHit[k] = (|(patK & resK))
                      | (patK[RB_MUL] & resK[RB_F1])
                      | (patK[RB_F1]  & resK[RB_MUL]);
  end

  assign conflict   = |slotHit;
  assign knownClass = (cls != CLS_NONE);

  always_comb begin
    accept         = reqValid && knownClass && !conflict;
    stall          = reqValid && knownClass && conflict;
    strobe.merge   = accept;
    strobe.launch  = accept;
    strobe.latency = classLatency(cls);
  end

endmodule

// File: rtl/fpu_sb_datapath.sv
module fpu_sb_datapath
  import fpu_sb_pkg::*;
#(
  parameter int DEPTH  = PAT_DEPTH,
  parameter int LATMAX = LAT_MAX
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strobe,
  input  logic [DEPTH-1:0][RES_W-1:0] pattern,
  output logic [DEPTH-1:0][RES_W-1:0] resvView,
  output logic                  resultReady
);

  logic [DEPTH-1:0][RES_W-1:0] resvQ, resvD;
  logic [LATMAX-1:0]           pendQ, pendD;

  // Slot k holds use for the cycle k+1 ahead; merge then advance.
  for (genvar k = 0; k < DEPTH; k++) begin : g_resv
    if (k == DEPTH - 1) begin : g_top
      assign resvD[k] = '0;
    end else begin : g_mid
      assign resvD[k] = resvQ[k+1] | (strobe.merge ? pattern[k+1] : '0);
    end
  end

  // Bit j fires j+1 cycles from now.
  for (genvar j = 0; j < LATMAX; j++) begin : g_pend
    logic launchHere;
    assign launchHere = strobe.launch && (strobe.latency == LAT_W'(j + 1));
    if (j == LATMAX - 1) begin : g_top
      assign pendD[j] = launchHere;
    end else begin : g_mid
      assign pendD[j] = pendQ[j+1] | launchHere;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resvQ <= '0;
      pendQ <= '0;
    end else begin
      resvQ <= resvD;
      pendQ <= pendD;
    end
  end

  assign resvView    = resvQ;
  assign resultReady = pendQ[0];

endmodule

// File: rtl/fpu_stage_scoreboard.sv
module fpu_stage_scoreboard
  import fpu_sb_pkg::*;
#(
  parameter int DEPTH  = PAT_DEPTH,
  parameter int LATMAX = LAT_MAX
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [CLS_W-1:0] reqClass,
  output logic             accept,
  output logic             stall,
  output logic             resultReady
);

  logic [DEPTH-1:0][RES_W-1:0] resvView;
  logic [DEPTH-1:0][RES_W-1:0] pattern;
  ctrlStrobe_t                 strobe;

  fpu_sb_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .reqValid (reqValid),
    .reqClass (reqClass),
    .resvView (resvView),
    .pattern  (pattern),
    .strobe   (strobe),
    .accept   (accept),
    .stall    (stall)
  );

  fpu_sb_datapath #(.DEPTH(DEPTH), .LATMAX(LATMAX)) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .pattern     (pattern),
    .resvView    (resvView),
    .resultReady (resultReady)
  );

endmodule

// File: rtl/fpu_sb_checker.sv
module fpu_sb_checker (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic [2:0] reqClass,
  input logic       accept,
  input logic       stall,
  input logic       resultReady
);

  assert_no_dual_outcome_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(accept && stall));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (!accept && !stall));

  assert_code7_ignored_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqClass == 3'd7) |-> (!accept && !stall));

  assert_sp_latency_R4: assert property (@(posedge clk) disable iff (!rstN)
    (accept && reqClass == 3'd0) |-> ##3 resultReady);

  assert_conv_latency_R8: assert property (@(posedge clk) disable iff (!rstN)
    (accept && reqClass == 3'd4) |-> ##4 resultReady);

  assert_mul_excludes_stage1_R9: assert property (@(posedge clk) disable iff (!rstN)
    (accept && reqClass == 3'd5) ##1 (reqValid && reqClass == 3'd0) |-> stall);

  assert_quiet_after_reset_R11: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> !resultReady);

endmodule

bind fpu_stage_scoreboard fpu_sb_checker i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqClass    (reqClass),
  .accept      (accept),
  .stall       (stall),
  .resultReady (resultReady)
);

// File: tb/test_fpu_stage_scoreboard.sv
module test_fpu_stage_scoreboard;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [2:0] reqClass = 3'd0;
  logic       accept, stall, resultReady;
  logic       sAcc, sStall, sReady;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  fpu_stage_scoreboard i_fpu_stage_scoreboard (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqClass    (reqClass),
    .accept      (accept),
    .stall       (stall),
    .resultReady (resultReady)
  );

  // {valid, class[2:0], expAccept, expStall, expReady}, one per cycle.
  localparam int NVEC = 19;
  localparam logic [6:0] VEC [NVEC] = '{
    {1'b1, 3'd0, 1'b1, 1'b0, 1'b0},
    {1'b1, 3'd0, 1'b1, 1'b0, 1'b0},
    {1'b1, 3'd4, 1'b1, 1'b0, 1'b0},
    {1'b1, 3'd0, 1'b0, 1'b1, 1'b1},
    {1'b1, 3'd0, 1'b1, 1'b0, 1'b1},
    {1'b1, 3'd5, 1'b1, 1'b0, 1'b0},
    {1'b1, 3'd6, 1'b0, 1'b1, 1'b1},
    {1'b0, 3'd0, 1'b0, 1'b0, 1'b1},
    {1'b1, 3'd7, 1'b0, 1'b0, 1'b0},
    {1'b1, 3'd0, 1'b1, 1'b0, 1'b1},
    {1'b1, 3'd6, 1'b1, 1'b0, 1'b0},
    {1'b1, 3'd4, 1'b0, 1'b1, 1'b0},
    {1'b0, 3'd0, 1'b0, 1'b0, 1'b1},
    {1'b1, 3'd0, 1'b0, 1'b1, 1'b0},
    {1'b1, 3'd0, 1'b1, 1'b0, 1'b1},
    {1'b0, 3'd0, 1'b0, 1'b0, 1'b0},
    {1'b0, 3'd0, 1'b0, 1'b0, 1'b0},
    {1'b0, 3'd0, 1'b0, 1'b0, 1'b1},
    {1'b0, 3'd0, 1'b0, 1'b0, 1'b0}
  };

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic runCycle(input logic v, input logic [2:0] c);
    @(negedge clk);
    reqValid = v;
    reqClass = c;
    #2;
    sAcc   = accept;
    sStall = stall;
    sReady = resultReady;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    reqValid = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic measureLatency(input string tag, input logic [2:0] c, input int lat);
    int found;
    found = 0;
    doReset();
    runCycle(1'b1, c);
    check({tag, " accept"}, int'(sAcc), 1);
    for (int k = 1; k <= 40; k++) begin
      runCycle(1'b0, 3'd0);
      if (sReady && found == 0) found = k;
    end
    check({tag, " latency"}, found, lat);
  endtask

  task automatic probe(input string tag, input logic [2:0] first, input int d,
                       input logic [2:0] second, input logic expAcc);
    doReset();
    runCycle(1'b1, first);
    for (int i = 1; i < d; i++) runCycle(1'b0, 3'd0);
    runCycle(1'b1, second);
    check({tag, " accept"}, int'(sAcc), int'(expAcc));
    check({tag, " stall"}, int'(sStall), int'(!expAcc));
  endtask

  initial begin
    int pulses;

    doReset();
    runCycle(1'b0, 3'd0);
    check("R11 ready after reset", int'(sReady), 0);
    check("R1 idle accept", int'(sAcc), 0);

    // Vector walk (R1, R2, R3, R4, R8, R9, R10, R12).
    doReset();
    for (int n = 0; n < NVEC; n++) begin
      runCycle(VEC[n][6], VEC[n][5:3]);
      check($sformatf("R2 vec%0d accept", n), int'(sAcc),   int'(VEC[n][2]));
      check($sformatf("R2 vec%0d stall", n),  int'(sStall), int'(VEC[n][1]));
      check($sformatf("R4 vec%0d ready", n),  int'(sReady), int'(VEC[n][0]));
    end

    // Latencies per class.
    measureLatency("R4", 3'd0, 3);
    measureLatency("R5", 3'd1, 12);
    measureLatency("R6", 3'd2, 8);
    measureLatency("R7", 3'd3, 25);
    measureLatency("R8", 3'd4, 4);
    measureLatency("R9", 3'd5, 4);
    measureLatency("R10", 3'd6, 4);

    // Plan extents and window advance.
    probe("R5 div d8 arith",  3'd1, 8,  3'd0, 1'b1);
    probe("R5 div d9 arith",  3'd1, 9,  3'd0, 1'b0);
    probe("R5 div d10 arith", 3'd1, 10, 3'd0, 1'b1);
    probe("R5 div d9 div",    3'd1, 9,  3'd1, 1'b0);
    probe("R12 div d10 div",  3'd1, 10, 3'd1, 1'b1);
    probe("R6 dpar d5",       3'd2, 5,  3'd0, 1'b0);
    probe("R6 dpar d6",       3'd2, 6,  3'd0, 1'b1);
    probe("R7 dpdiv d5",      3'd3, 5,  3'd0, 1'b1);
    probe("R7 dpdiv d19",     3'd3, 19, 3'd0, 1'b0);
    probe("R7 dpdiv d21 div", 3'd3, 21, 3'd1, 1'b0);
    probe("R7 dpdiv d22 div", 3'd3, 22, 3'd1, 1'b1);
    probe("R8 conv d1",       3'd4, 1,  3'd0, 1'b0);
    probe("R8 conv d2",       3'd4, 2,  3'd0, 1'b1);
    probe("R9 mul d1 arith",  3'd5, 1,  3'd0, 1'b0);
    probe("R9 mul d2 stat",   3'd5, 2,  3'd6, 1'b0);
    probe("R10 mul d3 stat",  3'd5, 3,  3'd6, 1'b1);
    probe("R9 mul d3 mul",    3'd5, 3,  3'd5, 1'b0);
    probe("R12 mul d4 mul",   3'd5, 4,  3'd5, 1'b1);
    probe("R10 stat d3",      3'd6, 3,  3'd0, 1'b0);
    probe("R10 stat d4",      3'd6, 4,  3'd0, 1'b1);

    // R2: a stalled request leaves no pulse.
    doReset();
    runCycle(1'b1, 3'd2);
    runCycle(1'b1, 3'd0);
    check("R2 stalled", int'(sStall), 1);
    pulses = 0;
    for (int k = 2; k <= 7; k++) begin
      runCycle(1'b0, 3'd0);
      pulses += int'(sReady);
    end
    check("R2 no pulse from stalled", pulses, 0);
    runCycle(1'b0, 3'd0);
    check("R2 older pulse at 8", int'(sReady), 1);

    // R3: code 7 does nothing.
    doReset();
    runCycle(1'b1, 3'd7);
    check("R3 accept", int'(sAcc), 0);
    check("R3 stall", int'(sStall), 0);
    pulses = 0;
    for (int k = 1; k <= 30; k++) begin
      runCycle(1'b0, 3'd0);
      pulses += int'(sReady);
    end
    check("R3 no pulse", pulses, 0);

    // R11: reset in flight clears reservations and pulses.
    doReset();
    runCycle(1'b1, 3'd3);
    repeat (5) runCycle(1'b0, 3'd0);
    doReset();
    runCycle(1'b1, 3'd1);
    check("R11 accept after reset", int'(sAcc), 1);
    pulses = 0;
    for (int k = 1; k <= 30; k++) begin
      runCycle(1'b0, 3'd0);
      pulses += int'(sReady);
    end
    check("R11 only own pulse", pulses, 1);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(1_000_000);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule